// File: doc/BRIEF.md
# Interleaved Write-Data Acceptance Controller

This block sits on the slave side of an AXI3 write path. It decides, one beat at a time, whether a write-data beat may be taken when the master mixes data from bursts with different IDs. Accepted write addresses go into an ordered queue. Only the oldest `WIN` entries of that queue form the acceptance window, and only those entries may receive data. `WIN` is the write interleaving depth. The queue itself may hold more entries than the window. Each window entry counts its beats. When the final beat of a burst arrives, the entry leaves the queue, the entries behind it move forward, and a write response carrying that burst's ID is raised.

Accepted beats appear on a plain write-port output: an enable, the ID, the data and the beat index within the burst. A storage array or a downstream pipeline uses this port. A beat that cannot be placed in the window is never taken. It waits with `w_ready` low until its address reaches the window.

The response path is a two-state machine. In `RSP_IDLE` no response is offered. The transition `load` moves it to `RSP_PEND` when a burst retires. In `RSP_PEND`, `b_valid` is high. The transition `handoff` returns it to `RSP_IDLE` when `b_ready` is seen and no new retirement arrives in the same cycle. If a new retirement does arrive in that cycle, the machine stays in `RSP_PEND` with the new ID (`reload`).

Top module: `wil_accept_ctrl`

## Requirements
- R1: After reset the queue is empty, `aw_ready` is 1, and `w_ready` and `b_valid` are 0.
- R2: `aw_ready` is 1 while fewer than `QDEPTH` addresses are queued, including when more than `WIN` are queued. It is 0 only when the queue holds `QDEPTH` addresses.
- R3: A valid beat is accepted in the same cycle (`w_ready`=1) when its `w_id` equals the ID of one of the oldest `WIN` queued addresses. Beats of different IDs in the window may alternate freely.
- R4: A beat whose `w_id` matches no queued address, or matches only addresses behind the window, sees `w_ready`=0.
- R5: A beat presented in the same cycle as its address handshake, or before it, is not accepted. It becomes acceptable from the cycle after the address handshake, once that address lies in the window.
- R6: Accepting a beat with `w_last`=1 removes its entry from the queue at that clock edge. Later entries move forward one place, so the next queued address joins the window and one queue slot is freed for `aw_ready`.
- R7: When several window entries share a `w_id`, the beat goes to the oldest of them. The next entry with that ID receives data only after the older one has retired.
- R8: A retirement produces `b_valid`=1 from the next cycle, with `b_id` equal to the retired address's ID and `b_resp`=2'b00 (OKAY). `b_valid` and `b_id` hold until a cycle with `b_ready`=1.
- R9: A final beat (`w_last`=1) is held off (`w_ready`=0) while a response is pending and `b_ready` is 0. With `b_ready`=1 it is accepted, and the new response replaces the one handed off.
- R10: With `WIN`=1, data is accepted strictly in address order: only the oldest queued address can receive a beat.
- R11: For each accepted beat, `wr_en`=1 and `wr_id`/`wr_data` equal `w_id`/`w_data`. `wr_beat` is the beat index within its burst, starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Address queue has room |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | 4 | Beats in burst minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Beat accepted this cycle |
| w_id | input | ID_W | Write data ID |
| w_data | input | DATA_W | Write data |
| w_last | input | 1 | Final beat of burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | ID_W | Response ID |
| b_resp | output | 2 | Response code, always OKAY |
| wr_en | output | 1 | Accepted beat strobe |
| wr_id | output | ID_W | ID of accepted beat |
| wr_data | output | DATA_W | Data of accepted beat |
| wr_beat | output | 4 | Index of accepted beat in its burst |

## Verification
The main function is tried with two interleaved bursts whose beats alternate, a beat offered before its address, a beat whose ID lies only behind the window, and a queue filled beyond the window until `aw_ready` drops. Together these separate a design that matches the whole queue from one that matches only the window, and an address-count limit from a window limit. Two bursts with the same ID check that beats go to the oldest entry. A retirement while the response is stalled, and another while it is being handed off, check the hold-off on final beats. A second instance with a window of one checks that data is accepted strictly in address order.

// File: rtl/wil_pkg.sv
package wil_pkg;
    localparam int unsigned LEN_W = 4;          // AXI3 burst length field
    localparam logic [1:0]  RESP_OKAY = 2'b00;

    typedef enum logic {
        RSP_IDLE,
        RSP_PEND
    } rsp_state_t;
endpackage

// File: rtl/wil_addr_queue.sv
module wil_addr_queue #(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned QDEPTH = 5,
    parameter int unsigned WIN    = 2,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned SLOT_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ID_W-1:0]            push_id,
    input  logic [LEN_W-1:0]           push_len,
    input  logic                       beat,
    input  logic [SLOT_W-1:0]          beat_slot,
    input  logic                       beat_last,
    output logic [CNT_W-1:0]           count,
    output logic [WIN-1:0][ID_W-1:0]   win_id,
    output logic [WIN-1:0][LEN_W-1:0]  win_cnt,
    output logic [WIN-1:0]             win_valid
);
    logic [QDEPTH-1:0][ID_W-1:0]  id_q,  n_id;
    logic [QDEPTH-1:0][LEN_W-1:0] len_q, n_len;
    logic [QDEPTH-1:0][LEN_W-1:0] cnt_q, n_cnt;
    logic [CNT_W-1:0]             n_count;

    always_comb begin
        n_id    = id_q;
        n_len   = len_q;
        n_cnt   = cnt_q;
        n_count = count;
        if (beat) begin
            if (beat_last) begin
                for (int i = 0; i < QDEPTH - 1; i++) begin
                    if (i >= int'(beat_slot)) begin
                        n_id[i]  = id_q[i+1];
                        n_len[i] = len_q[i+1];
                        n_cnt[i] = cnt_q[i+1];
                    end
                end
                n_count = count - CNT_W'(1);
            end else begin
                n_cnt[beat_slot] = cnt_q[beat_slot] + LEN_W'(1);
            end
        end
        if (push) begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (n_count == CNT_W'(i)) begin
                    n_id[i]  = push_id;
                    n_len[i] = push_len;
                    n_cnt[i] = '0;
                end
            end
            n_count = n_count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            len_q <= '0;
            cnt_q <= '0;
            count <= '0;
        end else begin
            id_q  <= n_id;
            len_q <= n_len;
            cnt_q <= n_cnt;
            count <= n_count;
        end
    end

    for (genvar k = 0; k < WIN; k++) begin : g_win
        assign win_id[k]    = id_q[k];
        assign win_cnt[k]   = cnt_q[k];
        assign win_valid[k] = (count > CNT_W'(k));
    end
endmodule

// File: rtl/wil_window_match.sv
module wil_window_match #(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned WIN    = 2,
    parameter int unsigned SLOT_W = 1
) (
    input  logic [WIN-1:0][ID_W-1:0] win_id,
    input  logic [WIN-1:0]           win_valid,
    input  logic [ID_W-1:0]          w_id,
    output logic                     hit,
    output logic [SLOT_W-1:0]        slot
);
    logic [WIN-1:0] eq;

    for (genvar k = 0; k < WIN; k++) begin : g_cmp
        assign eq[k] = win_valid[k] && (win_id[k] == w_id);
    end

    // Scan from the youngest slot down, so the oldest match wins.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int k = WIN - 1; k >= 0; k--) begin
            if (eq[k]) begin
                hit  = 1'b1;
                slot = SLOT_W'(k);
            end
        end
    end
endmodule

// File: rtl/wil_resp_fsm.sv
module wil_resp_fsm
    import wil_pkg::*;
#(
    parameter int unsigned ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ID_W-1:0] load_id,
    input  logic            b_ready,
    output logic            b_valid,
    output logic [ID_W-1:0] b_id,
    output logic            blocked
);
    rsp_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            RSP_IDLE: if (load) nxt = RSP_PEND;                // load
            RSP_PEND: if (b_ready && !load) nxt = RSP_IDLE;    // handoff; else reload or hold
            default:  nxt = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RSP_IDLE;
            b_id  <= '0;
        end else begin
            state <= nxt;
            if (load) b_id <= load_id;
        end
    end

    always_comb begin
        b_valid = (state == RSP_PEND);
        blocked = (state == RSP_PEND) && !b_ready;
    end
endmodule

// File: rtl/wil_accept_ctrl.sv
module wil_accept_ctrl
    import wil_pkg::*;
#(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned QDEPTH = 5,
    parameter int unsigned WIN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [ID_W-1:0]   w_id,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    output logic              wr_en,
    output logic [ID_W-1:0]   wr_id,
    output logic [DATA_W-1:0] wr_data,
    output logic [LEN_W-1:0]  wr_beat
);
    localparam int unsigned CNT_W  = $clog2(QDEPTH + 1);
    localparam int unsigned SLOT_W = (WIN > 1) ? $clog2(WIN) : 1;

    initial begin
        if (WIN < 1 || WIN > QDEPTH) $error("window must be 1..QDEPTH");
    end

    logic [CNT_W-1:0]            q_count;
    logic [WIN-1:0][ID_W-1:0]    win_id;
    logic [WIN-1:0][LEN_W-1:0]   win_cnt;
    logic [WIN-1:0]              win_valid;
    logic                        hit;
    logic [SLOT_W-1:0]           slot;
    logic                        rsp_blocked;
    logic                        push, beat, retire;

    assign aw_ready = (q_count < CNT_W'(QDEPTH));
    assign push     = aw_valid && aw_ready;
    assign w_ready  = w_valid && hit && !(w_last && rsp_blocked);
    assign beat     = w_valid && w_ready;
    assign retire   = beat && w_last;

    wil_addr_queue #(
        .ID_W(ID_W), .LEN_W(LEN_W), .QDEPTH(QDEPTH), .WIN(WIN),
        .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) i_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_id(aw_id), .push_len(aw_len),
        .beat(beat), .beat_slot(slot), .beat_last(w_last),
        .count(q_count), .win_id(win_id), .win_cnt(win_cnt), .win_valid(win_valid)
    );

    wil_window_match #(.ID_W(ID_W), .WIN(WIN), .SLOT_W(SLOT_W)) i_match (
        .win_id(win_id), .win_valid(win_valid), .w_id(w_id),
        .hit(hit), .slot(slot)
    );

    wil_resp_fsm #(.ID_W(ID_W)) i_resp (
        .clk(clk), .rst_n(rst_n),
        .load(retire), .load_id(w_id), .b_ready(b_ready),
        .b_valid(b_valid), .b_id(b_id), .blocked(rsp_blocked)
    );

    assign b_resp  = RESP_OKAY;
    assign wr_en   = beat;
    assign wr_id   = w_id;
    assign wr_data = w_data;
    assign wr_beat = win_cnt[slot];
endmodule

// File: rtl/wil_accept_checker.sv
module wil_accept_checker #(
    parameter int unsigned ID_W   = 4,
    parameter int unsigned QDEPTH = 5,
    parameter int unsigned WIN    = 2,
    parameter int unsigned CNT_W  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            aw_valid,
    input logic            aw_ready,
    input logic            w_valid,
    input logic            w_ready,
    input logic            w_last,
    input logic [ID_W-1:0] w_id,
    input logic            b_valid,
    input logic            b_ready,
    input logic [ID_W-1:0] b_id,
    input logic [CNT_W-1:0] q_count,
    input logic [ID_W-1:0] head_id
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH)); // R2
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && !(w_valid && w_ready && w_last))
        |=> q_count == $past(q_count) + CNT_W'(1)); // R2
    AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        w_ready |-> (q_count != '0)); // R5
    AST_RETIRE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && w_last) |=> (b_valid && b_id == $past(w_id))); // R6
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id))); // R8
    AST_STRICT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (WIN == 1 && w_ready) |-> (w_id == head_id)); // R10
endmodule

bind wil_accept_ctrl wil_accept_checker #(
    .ID_W(ID_W), .QDEPTH(QDEPTH), .WIN(WIN), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last), .w_id(w_id),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
    .q_count(q_count), .head_id(win_id[0])
);

// File: tb/test_wil_accept_ctrl.sv
module test_wil_accept_ctrl;
    localparam int PERIOD = 10;
    localparam int NROW   = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0, w_valid = 1'b0, w_last = 1'b0, b_ready = 1'b0;
    logic [3:0]  aw_id = '0, aw_len = '0, w_id = '0;
    logic [31:0] w_data = '0;
    logic        aw_ready, w_ready, b_valid, wr_en;
    logic [3:0]  b_id, wr_id, wr_beat;
    logic [1:0]  b_resp;
    logic [31:0] wr_data;

    // second instance, window of one
    logic        s_awv = 1'b0, s_wv = 1'b0, s_wl = 1'b0, s_br = 1'b0;
    logic [3:0]  s_awid = '0, s_wid = '0;
    logic        s_awr, s_wr, s_bv, s_wen;
    logic [3:0]  s_bid, s_wrid, s_wrbeat;
    logic [1:0]  s_bresp;
    logic [31:0] s_wrdata;

    int tests = 0, fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    wil_accept_ctrl i_wil_accept_ctrl (
        .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_id(aw_id), .aw_len(aw_len), .w_valid(w_valid), .w_ready(w_ready),
        .w_id(w_id), .w_data(w_data), .w_last(w_last), .b_valid(b_valid),
        .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp), .wr_en(wr_en),
        .wr_id(wr_id), .wr_data(wr_data), .wr_beat(wr_beat)
    );

    wil_accept_ctrl #(.WIN(1)) i_wil_accept_ctrl_w1 (
        .clk(clk), .rst_n(rst_n), .aw_valid(s_awv), .aw_ready(s_awr),
        .aw_id(s_awid), .aw_len(4'd0), .w_valid(s_wv), .w_ready(s_wr),
        .w_id(s_wid), .w_data(32'h0), .w_last(s_wl), .b_valid(s_bv),
        .b_ready(s_br), .b_id(s_bid), .b_resp(s_bresp), .wr_en(s_wen),
        .wr_id(s_wrid), .wr_data(s_wrdata), .wr_beat(s_wrbeat)
    );

    // row: req, awv, awid, awlen, wv, wid, wlast, brdy | e_awr, e_wr, e_bv, e_bid, e_beat
    localparam logic [30:0] VEC [NROW] = '{
        {4'd5, 1'b1,4'd1,4'd1,  1'b1,4'd1,1'b0, 1'b0,  1'b1,1'b0,1'b0,4'd0,4'd0},  // R5 data before address
        {4'd3, 1'b1,4'd2,4'd1,  1'b1,4'd1,1'b0, 1'b0,  1'b1,1'b1,1'b0,4'd0,4'd0},  // R3
        {4'd5, 1'b1,4'd3,4'd0,  1'b1,4'd3,1'b1, 1'b0,  1'b1,1'b0,1'b0,4'd0,4'd0},  // R5 same cycle as AW
        {4'd4, 1'b0,4'd0,4'd0,  1'b1,4'd3,1'b1, 1'b0,  1'b1,1'b0,1'b0,4'd0,4'd0},  // R4 behind window
        {4'd3, 1'b0,4'd0,4'd0,  1'b1,4'd2,1'b0, 1'b0,  1'b1,1'b1,1'b0,4'd0,4'd0},  // R3 interleave
        {4'd11,1'b0,4'd0,4'd0,  1'b1,4'd1,1'b1, 1'b0,  1'b1,1'b1,1'b0,4'd0,4'd1},  // R11 beat index 1
        {4'd9, 1'b0,4'd0,4'd0,  1'b1,4'd3,1'b1, 1'b0,  1'b1,1'b0,1'b1,4'd1,4'd0},  // R9 held off
        {4'd8, 1'b1,4'd4,4'd0,  1'b0,4'd0,1'b0, 1'b0,  1'b1,1'b0,1'b1,4'd1,4'd0},  // R8 hold
        {4'd8, 1'b0,4'd0,4'd0,  1'b0,4'd0,1'b0, 1'b1,  1'b1,1'b0,1'b1,4'd1,4'd0},  // R8 handoff
        {4'd6, 1'b1,4'd5,4'd0,  1'b1,4'd3,1'b1, 1'b0,  1'b1,1'b1,1'b0,4'd0,4'd0},  // R6
        {4'd9, 1'b1,4'd6,4'd0,  1'b1,4'd2,1'b1, 1'b1,  1'b1,1'b1,1'b1,4'd3,4'd1},  // R9 reload
        {4'd8, 1'b1,4'd7,4'd0,  1'b0,4'd0,1'b0, 1'b1,  1'b1,1'b0,1'b1,4'd2,4'd0},  // R8
        {4'd2, 1'b1,4'd8,4'd0,  1'b0,4'd0,1'b0, 1'b0,  1'b1,1'b0,1'b0,4'd0,4'd0},  // R2 four queued
        {4'd2, 1'b1,4'd9,4'd0,  1'b0,4'd0,1'b0, 1'b0,  1'b0,1'b0,1'b0,4'd0,4'd0},  // R2 full
        {4'd4, 1'b0,4'd0,4'd0,  1'b1,4'd6,1'b1, 1'b0,  1'b0,1'b0,1'b0,4'd0,4'd0},  // R4
        {4'd3, 1'b0,4'd0,4'd0,  1'b1,4'd5,1'b1, 1'b0,  1'b0,1'b1,1'b0,4'd0,4'd0},  // R3 slot 1
        {4'd6, 1'b0,4'd0,4'd0,  1'b0,4'd0,1'b0, 1'b1,  1'b1,1'b0,1'b1,4'd5,4'd0},  // R6 slot freed
        {4'd6, 1'b0,4'd0,4'd0,  1'b1,4'd6,1'b1, 1'b0,  1'b1,1'b1,1'b0,4'd0,4'd0},  // R6 refill
        {4'd8, 1'b0,4'd0,4'd0,  1'b0,4'd0,1'b0, 1'b1,  1'b1,1'b0,1'b1,4'd6,4'd0},  // R8
        {4'd6, 1'b0,4'd0,4'd0,  1'b1,4'd4,1'b1, 1'b1,  1'b1,1'b1,1'b0,4'd0,4'd0},  // R6
        {4'd9, 1'b0,4'd0,4'd0,  1'b1,4'd7,1'b1, 1'b1,  1'b1,1'b1,1'b1,4'd4,4'd0},  // R9
        {4'd8, 1'b0,4'd0,4'd0,  1'b1,4'd8,1'b1, 1'b1,  1'b1,1'b1,1'b1,4'd7,4'd0},  // R8
        {4'd8, 1'b0,4'd0,4'd0,  1'b0,4'd0,1'b0, 1'b1,  1'b1,1'b0,1'b1,4'd8,4'd0},  // R8
        {4'd7, 1'b1,4'd10,4'd1, 1'b0,4'd0,1'b0, 1'b0,  1'b1,1'b0,1'b0,4'd0,4'd0},  // R7
        {4'd7, 1'b1,4'd10,4'd0, 1'b1,4'd10,1'b0,1'b0,  1'b1,1'b1,1'b0,4'd0,4'd0},  // R7
        {4'd7, 1'b0,4'd0,4'd0,  1'b1,4'd10,1'b1,1'b0,  1'b1,1'b1,1'b0,4'd0,4'd1},  // R7 older gets it
        {4'd7, 1'b0,4'd0,4'd0,  1'b1,4'd10,1'b1,1'b1,  1'b1,1'b1,1'b1,4'd10,4'd0}, // R7 younger restarts
        {4'd8, 1'b0,4'd0,4'd0,  1'b0,4'd0,1'b0, 1'b1,  1'b1,1'b0,1'b1,4'd10,4'd0}, // R8
        {4'd1, 1'b0,4'd0,4'd0,  1'b0,4'd0,1'b0, 1'b0,  1'b1,1'b0,1'b0,4'd0,4'd0}   // R1 idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 2000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        w_valid = 1'b1; w_id = 4'd1;
        #2;
        // R1 reset state
        check("R1 reset", {29'd0, aw_ready, w_ready, b_valid}, {29'd0, 1'b1, 1'b0, 1'b0});
        w_valid = 1'b0;

        for (int r = 0; r < NROW; r++) begin
            logic [30:0] v;
            logic [31:0] act, exp;
            @(negedge clk);
            v = VEC[r];
            aw_valid = v[26]; aw_id = v[25:22]; aw_len = v[21:18];
            w_valid  = v[17]; w_id  = v[16:13]; w_last = v[12];
            b_ready  = v[11];
            w_data   = 32'(r * 3 + 7);
            #2;
            act = {17'd0, aw_ready, w_ready, b_valid,
                   (b_valid ? b_id : 4'd0), (w_ready ? wr_beat : 4'd0),
                   (b_valid ? b_resp : 2'd0), 2'd0};
            exp = {17'd0, v[10], v[9], v[8], v[7:4], v[3:0], 2'd0, 2'd0};
            check($sformatf("R%0d row %0d", v[30:27], r), act, exp);
            if (w_ready) begin
                // R11 write-port contents
                check($sformatf("R11 row %0d", r), {wr_en, 23'd0, wr_id, 4'd0},
                      {1'b1, 23'd0, w_id, 4'd0});
                check($sformatf("R11 data row %0d", r), wr_data, 32'(r * 3 + 7));
            end
        end
        @(negedge clk);
        aw_valid = 0; w_valid = 0; b_ready = 0;

        // R10: window of one, strict address order
        s_awv = 1; s_awid = 4'd1;
        @(negedge clk);
        s_awid = 4'd2;
        @(negedge clk);
        s_awv = 0; s_wv = 1; s_wid = 4'd2; s_wl = 1;
        #2;
        check("R10 second address not eligible", {31'd0, s_wr}, 32'd0);
        @(negedge clk);
        s_wid = 4'd1;
        #2;
        check("R10 head address eligible", {31'd0, s_wr}, 32'd1);
        @(negedge clk);
        s_wid = 4'd2; s_br = 1;
        #2;
        check("R10 next after retire", {27'd0, s_wr, s_bv, s_bid}, {27'd0, 1'b1, 1'b1, 4'd1});
        @(negedge clk);
        s_wv = 0;
        #2;
        check("R8 w1 response id", {27'd0, s_bv, s_bresp == 2'b00, s_bid},
              {27'd0, 1'b1, 1'b1, 4'd2});

        // R1 reset mid-traffic
        @(negedge clk);
        aw_valid = 1; aw_id = 4'd3; aw_len = 4'd0;
        @(negedge clk);
        aw_valid = 0; rst_n = 0;
        @(negedge clk);
        rst_n = 1; w_valid = 1; w_id = 4'd3; w_last = 1;
        #2;
        check("R1 reset clears queue", {29'd0, aw_ready, w_ready, b_valid},
              {29'd0, 1'b1, 1'b0, 1'b0});
        w_valid = 0;
        @(negedge clk);
        finish_run();
    end
endmodule